// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block is a slave on a two-wire serial bus. It gives a host read access to a bank of 8-bit configuration registers that sit outside it. SCL and SDA are brought into the clock domain through synchronizer flops. The block finds START, repeated START and STOP from edge-detected copies of the two lines. It answers to a 7-bit device address whose upper six bits are fixed, `100110`. The lowest bit of that address comes from a strap pin, so the address is 0x4C with the strap low and 0x4D with it high.

The host first sends a write frame and then one byte, which becomes the register pointer. It then issues a repeated START with the read bit set and clocks out as many bytes as it needs. Each byte comes from the register the pointer currently selects, and the pointer steps by one after every byte. The block pulls SDA low only through an open-drain enable output. It reads the register bank through a combinational port, with the address presented as the pointer and the data returned in the same cycle.

Top module: `cfg_i2c_slave`

## Requirements
- R1: The device address is `{6'b100110, strap}`: 0x4C with `addr_strap_i` low and 0x4D with it high. An address frame carrying the other value is not acknowledged.
- R2: On an address match the slave acknowledges by holding SDA low (`sda_oe_o`=1) for the whole high phase of the ninth clock.
- R3: In a write transaction, the byte after the address frame is acknowledged and loaded into the register pointer. After its ninth clock, `reg_addr_o` equals that byte.
- R4: After a repeated START with the matching address and R/W=1, the slave returns `reg_rdata_i` for the register at `reg_addr_o`, MSB first, one bit per clock.
- R5: The pointer increments by one after each byte read, including the last byte of a burst, so a burst returns consecutive registers.
- R6: The pointer wraps from 0xFF to 0x00 during a read burst.
- R7: After a read byte that the master does not acknowledge (SDA high on the ninth clock), the slave drives no further bits and the pointer holds until the next START.
- R8: After an address frame that does not match, the slave does not drive SDA and the pointer stays unchanged until the next START.
- R9: A STOP returns the slave to idle with SDA released. A STOP in the middle of a frame aborts that frame, and a later START is served normally.
- R10: Further bytes in a write transaction after the pointer byte are not acknowledged and leave the pointer unchanged.
- R11: The slave starts driving SDA low only while SCL is low, and it releases SDA during the master's acknowledge bit of a read.
- R12: After reset `sda_oe_o` is 0 and `reg_addr_o` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line (asynchronous) |
| sda_i | input | 1 | Serial data line as seen on the pad (asynchronous) |
| addr_strap_i | input | 1 | Strap that sets the device address LSB |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| reg_addr_o | output | 8 | Register pointer, addresses the register bank |
| reg_rdata_i | input | 8 | Combinational read data of the addressed register |

## Verification
The bench builds the block with its default parameters: two synchronizer stages, an 8-bit pointer and the `100110` address prefix. With an 8-bit pointer, a burst that starts at 0xFE reaches the wrap to 0x00 within three bytes. The pointer value is chosen in the write phase, so any starting register can be reached without a long burst. Each half bit of the bus lasts eight clocks, which leaves room for the synchronizer and edge-detect latency before the bench samples SDA in the middle of each SCL high phase. Both strap values are exercised against both address values.

// File: rtl/cfg_i2c_slave.sv
module cfg_i2c_slave #(
  parameter logic [5:0] ADDR_HI = 6'b100110,
  parameter int         SYNC    = 2,
  parameter int         PTR_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic             addr_strap_i,
  output logic             sda_oe_o,
  output logic [PTR_W-1:0] reg_addr_o,
  input  logic [7:0]       reg_rdata_i
);
  localparam logic [3:0] S_IDLE = 4'd0, S_ADDR = 4'd1, S_AACK = 4'd2, S_PTR  = 4'd3,
                         S_PACK = 4'd4, S_SKIP = 4'd5, S_RD   = 4'd6, S_RACK = 4'd7,
                         S_WAIT = 4'd8;

  logic [SYNC-1:0] scl_s, sda_s;
  logic scl_q, sda_q, scl_d, sda_d;
  logic [3:0] state, cnt;
  logic [7:0] sr;
  logic [PTR_W-1:0] ptr;
  logic rw, mack, idle;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_s <= '1; sda_s <= '1; scl_d <= 1'b1; sda_d <= 1'b1;
    end else begin
      scl_s <= {scl_s[SYNC-2:0], scl_i};
      sda_s <= {sda_s[SYNC-2:0], sda_i};
      scl_d <= scl_q;
      sda_d <= sda_q;
    end

  assign scl_q = scl_s[SYNC-1];
  assign sda_q = sda_s[SYNC-1];

  wire start = scl_q & scl_d & sda_d & ~sda_q;
  wire stop  = scl_q & scl_d & ~sda_d & sda_q;
  wire rise  = scl_q & ~scl_d;
  wire fall  = ~scl_q & scl_d;
  wire match = sr[7:1] == {ADDR_HI, addr_strap_i};

  assign reg_addr_o = ptr;
  assign idle = state == S_IDLE;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state <= S_IDLE; cnt <= '0; sr <= '0; ptr <= '0;
      sda_oe_o <= 1'b0; rw <= 1'b0; mack <= 1'b0;
    end else if (start) begin
      state <= S_ADDR; cnt <= '0; sda_oe_o <= 1'b0;
    end else if (stop) begin
      state <= S_IDLE; sda_oe_o <= 1'b0;
    end else begin
      case (state)
        S_ADDR, S_PTR, S_SKIP:
          if (rise) begin
            sr  <= {sr[6:0], sda_q};
            cnt <= cnt + 4'd1;
          end else if (fall && cnt == 4'd8) begin
            cnt <= '0;
            if (state == S_ADDR) begin
              if (match) begin
                state <= S_AACK; rw <= sr[0]; sda_oe_o <= 1'b1;
              end else
                state <= S_IDLE;
            end else if (state == S_PTR) begin
              ptr <= PTR_W'(sr); state <= S_PACK; sda_oe_o <= 1'b1;
            end
          end
        S_AACK:
          if (fall) begin
            if (rw) begin
              sr <= reg_rdata_i; sda_oe_o <= ~reg_rdata_i[7]; cnt <= '0; state <= S_RD;
            end else begin
              sda_oe_o <= 1'b0; state <= S_PTR;
            end
          end
        S_PACK:
          if (fall) begin
            sda_oe_o <= 1'b0; state <= S_SKIP;
          end
        S_RD:
          if (rise) cnt <= cnt + 4'd1;
          else if (fall) begin
            if (cnt == 4'd8) begin
              sda_oe_o <= 1'b0; ptr <= ptr + 1'b1; cnt <= '0; state <= S_RACK;
            end else begin
              sr <= {sr[6:0], 1'b0}; sda_oe_o <= ~sr[6];
            end
          end
        S_RACK:
          if (rise) mack <= ~sda_q;
          else if (fall) begin
            if (mack) begin
              sr <= reg_rdata_i; sda_oe_o <= ~reg_rdata_i[7]; cnt <= '0; state <= S_RD;
            end else
              state <= S_WAIT;
          end
        default: ;
      endcase
    end
endmodule

module cfg_i2c_slave_chk #(parameter int PTR_W = 8) (
  input logic             clk,
  input logic             rst_n,
  input logic             scl_q,
  input logic             scl_d,
  input logic             sda_q,
  input logic             sda_d,
  input logic             idle,
  input logic             sda_oe_o,
  input logic [PTR_W-1:0] reg_addr_o
);
  a_r11_drive_low_phase: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe_o) |-> !scl_q);
  a_r5_ptr_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(reg_addr_o) |-> $past(scl_d && !scl_q));
  a_r9_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_q && scl_d && !sda_d && sda_q) |=> (!sda_oe_o && idle));
  a_r8_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !sda_oe_o);
  a_r12_start_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_q && scl_d && sda_d && !sda_q) |=> !sda_oe_o);
endmodule

bind cfg_i2c_slave cfg_i2c_slave_chk #(.PTR_W(PTR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .scl_q(scl_q), .scl_d(scl_d), .sda_q(sda_q),
  .sda_d(sda_d), .idle(idle), .sda_oe_o(sda_oe_o), .reg_addr_o(reg_addr_o));

// File: tb/cfg_i2c_slave_tb.sv
`timescale 1ns/1ps
module cfg_i2c_slave_tb_top;
  localparam int H = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1, strap = 1'b0;
  logic sda_oe;
  logic [7:0] raddr, rdata;
  wire sda_line = sda_m & ~sda_oe;
  int vectors = 0, errs = 0;
  int mptr = 0;

  always #4 clk = ~clk;

  function automatic logic [7:0] rf(input logic [7:0] a);
    return {a[3:0], a[7:4]} ^ 8'h3C;
  endfunction
  assign rdata = rf(raddr);

  cfg_i2c_slave dut_i (.clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .addr_strap_i(strap), .sda_oe_o(sda_oe), .reg_addr_o(raddr), .reg_rdata_i(rdata));

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic w(input int n); repeat (n) @(negedge clk); endtask

  task automatic b_start; sda_m = 1; scl = 1; w(H); sda_m = 0; w(H); scl = 0; w(H); endtask
  task automatic b_rstart; sda_m = 1; w(H); scl = 1; w(H); sda_m = 0; w(H); scl = 0; w(H); endtask
  task automatic b_stop; sda_m = 0; w(H); scl = 1; w(H); sda_m = 1; w(H); endtask

  task automatic b_bit(input logic o, output logic i);
    sda_m = o; w(H); scl = 1; w(H/2); i = sda_line; w(H/2); scl = 0;
  endtask

  task automatic wr_byte(input logic [7:0] b, input logic exp_ack, input string tag);
    logic a;
    for (int k = 7; k >= 0; k--) b_bit(b[k], a);
    b_bit(1'b1, a);
    chk(a == ~exp_ack, tag, a, ~exp_ack);
  endtask

  task automatic rd_byte(input logic [7:0] exp, input logic ack, input string tag);
    logic [7:0] v; logic a;
    for (int k = 7; k >= 0; k--) b_bit(1'b1, v[k]);
    chk(v == exp, tag, v, exp);
    b_bit(~ack, a);
    chk(sda_oe == 1'b0, "R11 release during master ack", sda_oe, 0);
  endtask

  task automatic burst(input logic [6:0] dev, input int start_ptr, input int n, input string tag);
    b_start;
    wr_byte({dev, 1'b0}, 1'b1, "R2 address ack (write)");
    wr_byte(8'(start_ptr), 1'b1, "R3 pointer ack");
    mptr = start_ptr;
    chk(raddr == 8'(mptr), "R3 pointer loaded", raddr, mptr);
    b_rstart;
    wr_byte({dev, 1'b1}, 1'b1, "R2 address ack (read)");
    for (int k = 0; k < n; k++) begin
      rd_byte(rf(8'(mptr)), k != n - 1, tag);
      mptr = (mptr + 1) & 255;
      chk(raddr == 8'(mptr), "R5 pointer advanced", raddr, mptr);
    end
    b_stop;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

  initial begin
    logic d;
    w(5);
    chk(sda_oe == 0, "R12 reset oe", sda_oe, 0);
    chk(raddr == 0, "R12 reset pointer", raddr, 0);
    rst_n = 1; w(4 * H);

    strap = 0;
    burst(7'h4C, 8'h10, 4, "R4 read data strap low");

    b_start;
    wr_byte({7'h4D, 1'b0}, 1'b0, "R1 wrong address not acked");
    wr_byte(8'h00, 1'b0, "R8 no drive after mismatch");
    chk(raddr == 8'(mptr), "R8 pointer kept", raddr, mptr);
    b_stop;

    strap = 1; w(4 * H);
    b_start;
    wr_byte({7'h4C, 1'b0}, 1'b0, "R1 0x4C ignored with strap high");
    b_stop;
    burst(7'h4D, 8'hFE, 4, "R6 wrap read strap high");
    chk(raddr == 8'h02, "R6 pointer after wrap", raddr, 2);

    b_start;
    wr_byte({7'h4D, 1'b0}, 1'b1, "R2 address ack");
    wr_byte(8'h40, 1'b1, "R3 pointer ack");
    wr_byte(8'h77, 1'b0, "R10 extra write byte not acked");
    chk(raddr == 8'h40, "R10 pointer kept", raddr, 8'h40);
    b_rstart;
    wr_byte({7'h4D, 1'b1}, 1'b1, "R2 address ack (read)");
    rd_byte(rf(8'h40), 1'b0, "R4 read after extra byte");
    rd_byte(8'hFF, 1'b0, "R7 no drive after master nack");
    chk(raddr == 8'h41, "R7 pointer held after nack", raddr, 8'h41);
    b_stop;

    b_start;
    b_bit(1'b1, d); b_bit(1'b0, d); b_bit(1'b0, d);
    b_stop;
    chk(sda_oe == 0, "R9 stop mid frame releases", sda_oe, 0);
    burst(7'h4D, 8'h80, 2, "R9 transaction after aborted frame");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end
endmodule